// File: doc/BRIEF.md
# Strided Rectangular DMA Engine

This engine copies a rectangle of data between a large external memory, addressed in bytes and accessed one 32-bit word at a time, and an 8 KB local scratchpad. The scratchpad is split into two 4 KB banks. Local address bit 12 chooses the bank: set means the instruction bank, clear means the data bank. A host first loads a local address register and an external address register. It then writes a packed descriptor that holds the row length, the row count and a skip stride. The register that receives the descriptor sets the direction and starts the transfer.

At start the engine forces alignment on both addresses. It rounds the row length up to a multiple of 8 bytes and shortens the row so that it cannot cross the end of the local bank. It then moves the rows one word at a time. The external side is a master port with a valid/ready handshake. The local side is a single-port synchronous RAM. After each row both address registers advance. The skip stride is added only on the destination side, and the host can read back the final addresses. While the engine works it holds `busy` high. When it finishes it gives a one-cycle `done` pulse.

Top module: `rdma_engine`

## Requirements
- R1: The register map is as follows. `regAddr` 0 is the local address, 1 is the external address, 2 is a descriptor that starts an external-to-local transfer, and 3 is a descriptor that starts a local-to-external transfer. Address 2 or 3 reads back the last descriptor accepted. In the descriptor, bits 11:0 hold the row length minus one, bits 19:12 hold the row count minus one, and bits 31:20 hold the skip stride in bytes.
- R2: The row length in bytes is the length field plus one, rounded up to the next multiple of 8. A field of 0 therefore moves 2 words per row.
- R3: When a transfer starts, the engine clears the two low bits of the local address and the three low bits of the external address. Every address the engine drives carries zeros in bits 1:0.
- R4: The engine takes the aligned local offset within its 4 KB bank (bits 11:0). If that offset plus the rounded length exceeds 4096, the row length becomes 4096 minus that offset.
- R5: Word k of a row (k counts from 0) uses the external address (ext + 4k) & 0x7FFFFC and the local address (loc + 4k) & 0x1FFC. Both addresses wrap, and the local bank is selected by bit 12.
- R6: In an external-to-local transfer, the external register advances by the row length after each row, and the local register advances by the row length plus the skip.
- R7: In a local-to-external transfer, the local register advances by the row length after each row, and the external register advances by the row length plus the skip.
- R8: A transfer moves exactly (count field + 1) rows. That is (count + 1) × length / 4 external handshakes.
- R9: While `extValid` is high and `extReady` is low, the engine holds the external request (address, direction, write data) steady, and it loses no word.
- R10: `busy` is high from the cycle after the start write until the last row has completed. `done` is then high for exactly one cycle, with `busy` already low.
- R11: Register writes that arrive while `busy` is high are ignored. This covers address writes and descriptor writes alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| extValid | output | 1 | External request valid |
| extWrite | output | 1 | External request is a write |
| extAddr | output | 23 | External byte address |
| extWdata | output | 32 | External write data |
| extReady | input | 1 | External request accepted this cycle |
| extRdata | input | 32 | External read data, valid with extReady |
| locEn | output | 1 | Local RAM enable |
| locWe | output | 1 | Local RAM write enable |
| locAddr | output | 13 | Local byte address |
| locWdata | output | 32 | Local RAM write data |
| locRdata | input | 32 | Local RAM read data, one cycle after a read |

## Verification
Most internal faults stay hidden until the transfer ends. A wrong row length, a missed clamp, a skip added on the wrong side or an off-by-one row count changes where words land in memory. It also changes the handshake count and the address values read back. All of these become visible within a cycle of `done`. Faults in the stall handling show at once at the external port as a request that changes while `extReady` is low. Faults in start decoding show in `busy` one cycle after the write.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LRD,
    ST_LCAP,
    ST_XFER,
    ST_ROWEND
  } rdmaState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic setup;    // align addresses, compute row length
    logic locRead;  // issue local RAM read
    logic capture;  // latch local RAM read data
    logic xfer;     // external request phase active
    logic rowEnd;   // advance address registers, next row
    logic toLocal;  // direction: external -> local
  } rdmaCtl_t;

endpackage

// File: rtl/rdma_datapath.sv
module rdma_datapath
  import rdma_pkg::*;
#(
  parameter int EXT_AW = 23,
  parameter int LOC_AW = 13,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 8,
  parameter int SKIP_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdmaCtl_t          ctl,
  input  logic              addrWr,
  input  logic              descLoad,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              lastWord,
  output logic              lastRow,
  output logic              extValid,
  output logic              extWrite,
  output logic [EXT_AW-1:0] extAddr,
  output logic [DATA_W-1:0] extWdata,
  input  logic              extReady,
  input  logic [DATA_W-1:0] extRdata,
  output logic              locEn,
  output logic              locWe,
  output logic [LOC_AW-1:0] locAddr,
  output logic [DATA_W-1:0] locWdata,
  input  logic [DATA_W-1:0] locRdata
);

  localparam int ROW_W = LEN_W + 1;
  localparam int OFF_W = LOC_AW - 1;
  localparam int BANK_BYTES = 1 << OFF_W;
  localparam logic [EXT_AW-1:0] EXT_MASK = {{(EXT_AW-2){1'b1}}, 2'b00};
  localparam logic [LOC_AW-1:0] LOC_MASK = {{(LOC_AW-2){1'b1}}, 2'b00};
  localparam int CNT_LSB = LEN_W;
  localparam int SKIP_LSB = LEN_W + CNT_W;

  logic [LOC_AW-1:0] locReg;
  logic [EXT_AW-1:0] extReg;
  logic [31:0]       descReg;
  logic [ROW_W-1:0]  rowLen;
  logic [ROW_W-1:0]  colOff;
  logic [CNT_W-1:0]  rowCnt;
  logic [DATA_W-1:0] holdData;

  logic [LEN_W-1:0]  lenField;
  logic [CNT_W-1:0]  cntField;
  logic [SKIP_W-1:0] skipField;
  logic [LOC_AW-1:0] locAligned;
  logic [ROW_W:0]    rounded, offset, rowSum, clampedLen;

  assign lenField  = descReg[LEN_W-1:0];
  assign cntField  = descReg[CNT_LSB +: CNT_W];
  assign skipField = descReg[SKIP_LSB +: SKIP_W];

  always_comb begin
    locAligned = locReg & LOC_MASK;
    rounded    = ((ROW_W+1)'(lenField) + (ROW_W+1)'(8)) & ~(ROW_W+1)'(7);
    offset     = (ROW_W+1)'(locAligned[OFF_W-1:0]);
    rowSum     = offset + rounded;
    clampedLen = (rowSum > (ROW_W+1)'(BANK_BYTES))
                 ? (ROW_W+1)'(BANK_BYTES) - offset : rounded;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locReg   <= '0;
      extReg   <= '0;
      descReg  <= '0;
      rowLen   <= '0;
      colOff   <= '0;
      rowCnt   <= '0;
      holdData <= '0;
    end else begin
      if (addrWr && !regAddr[0]) locReg <= regWrData[LOC_AW-1:0];
      if (addrWr &&  regAddr[0]) extReg <= regWrData[EXT_AW-1:0];
      if (descLoad) descReg <= regWrData;
      if (ctl.setup) begin
        locReg <= locAligned;
        extReg <= extReg & {{(EXT_AW-3){1'b1}}, 3'b000};
        rowLen <= clampedLen[ROW_W-1:0];
        colOff <= '0;
        rowCnt <= '0;
      end
      if (ctl.capture) holdData <= locRdata;
      if (ctl.xfer && extReady) colOff <= colOff + ROW_W'(4);
      if (ctl.rowEnd) begin
        colOff <= '0;
        rowCnt <= rowCnt + 1'b1;
        if (ctl.toLocal) begin
          extReg <= extReg + EXT_AW'(rowLen);
          locReg <= locReg + LOC_AW'(rowLen) + LOC_AW'(skipField);
        end else begin
          locReg <= locReg + LOC_AW'(rowLen);
          extReg <= extReg + EXT_AW'(rowLen) + EXT_AW'(skipField);
        end
      end
    end
  end

  assign lastWord = ({1'b0, colOff} + (ROW_W+1)'(4)) >= {1'b0, rowLen};
  assign lastRow  = (rowCnt == cntField);

  assign extValid = ctl.xfer;
  assign extWrite = ctl.xfer && !ctl.toLocal;
  assign extAddr  = (extReg + EXT_AW'(colOff)) & EXT_MASK;
  assign extWdata = holdData;

  assign locWe    = ctl.xfer && ctl.toLocal && extReady;
  assign locEn    = ctl.locRead || locWe;
  assign locAddr  = (locReg + LOC_AW'(colOff)) & LOC_MASK;
  assign locWdata = extRdata;

  always_comb begin
    if (regAddr[1])      regRdData = descReg;
    else if (regAddr[0]) regRdData = 32'(extReg);
    else                 regRdData = 32'(locReg);
  end

endmodule

// File: rtl/rdma_control.sv
module rdma_control
  import rdma_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     startToLocal,
  input  logic     extReady,
  input  logic     lastWord,
  input  logic     lastRow,
  output rdmaCtl_t ctl,
  output logic     busy,
  output logic     done
);

  rdmaState_e state, stateNext;
  logic       toLocal;
  rdmaState_e wordStart;

  assign wordStart = toLocal ? ST_XFER : ST_LRD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      toLocal <= 1'b0;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_ROWEND) && lastRow;
      if (start && state == ST_IDLE) toLocal <= startToLocal;
    end
  end

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    ctl.toLocal = toLocal;
    unique case (state)
      ST_IDLE:   if (start) stateNext = ST_SETUP;
      ST_SETUP: begin
        ctl.setup = 1'b1;
        stateNext = wordStart;
      end
      ST_LRD: begin
        ctl.locRead = 1'b1;
        stateNext   = ST_LCAP;
      end
      ST_LCAP: begin
        ctl.capture = 1'b1;
        stateNext   = ST_XFER;
      end
      ST_XFER: begin
        ctl.xfer = 1'b1;
        if (extReady) stateNext = lastWord ? ST_ROWEND : wordStart;
      end
      ST_ROWEND: begin
        ctl.rowEnd = 1'b1;
        stateNext  = lastRow ? ST_IDLE : wordStart;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
  import rdma_pkg::*;
#(
  parameter int EXT_AW = 23,
  parameter int LOC_AW = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              busy,
  output logic              done,
  output logic              extValid,
  output logic              extWrite,
  output logic [EXT_AW-1:0] extAddr,
  output logic [DATA_W-1:0] extWdata,
  input  logic              extReady,
  input  logic [DATA_W-1:0] extRdata,
  output logic              locEn,
  output logic              locWe,
  output logic [LOC_AW-1:0] locAddr,
  output logic [DATA_W-1:0] locWdata,
  input  logic [DATA_W-1:0] locRdata
);

  rdmaCtl_t ctl;
  logic     lastWord, lastRow;
  logic     accept, start, addrWr;

  assign accept = regWrEn && !busy;
  assign start  = accept && regAddr[1];
  assign addrWr = accept && !regAddr[1];

  rdma_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .startToLocal (!regAddr[0]),
    .extReady     (extReady),
    .lastWord     (lastWord),
    .lastRow      (lastRow),
    .ctl          (ctl),
    .busy         (busy),
    .done         (done)
  );

  rdma_datapath #(
    .EXT_AW (EXT_AW),
    .LOC_AW (LOC_AW),
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .addrWr    (addrWr),
    .descLoad  (start),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .lastWord  (lastWord),
    .lastRow   (lastRow),
    .extValid  (extValid),
    .extWrite  (extWrite),
    .extAddr   (extAddr),
    .extWdata  (extWdata),
    .extReady  (extReady),
    .extRdata  (extRdata),
    .locEn     (locEn),
    .locWe     (locWe),
    .locAddr   (locAddr),
    .locWdata  (locWdata),
    .locRdata  (locRdata)
  );

endmodule

// File: rtl/rdma_engine_sva.sv
module rdma_engine_sva #(
  parameter int EXT_AW = 23,
  parameter int LOC_AW = 13,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              extValid,
  input logic              extWrite,
  input logic [EXT_AW-1:0] extAddr,
  input logic [DATA_W-1:0] extWdata,
  input logic              extReady,
  input logic              locEn,
  input logic              locWe,
  input logic [LOC_AW-1:0] locAddr
);

  // R3: every driven address is word aligned
  p_ext_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    extValid |-> extAddr[1:0] == 2'b00);
  p_loc_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    locEn |-> locAddr[1:0] == 2'b00);

  // R9: a stalled request holds still
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (extValid && !extReady) |=> (extValid && $stable(extAddr)
      && $stable(extWrite) && $stable(extWdata)));

  // R9: local write only on an accepted external read
  p_loc_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    locWe |-> (extValid && extReady && !extWrite));

  // R10: done is a single-cycle pulse outside busy
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  // R10: no traffic while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!extValid && !locEn));

endmodule

bind rdma_engine rdma_engine_sva #(
  .EXT_AW (EXT_AW),
  .LOC_AW (LOC_AW),
  .DATA_W (DATA_W)
) u_sva (.*);

// File: tb/test_rdma_engine.sv
module test_rdma_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        busy, done;
  logic        extValid, extWrite, extReady = 1'b0;
  logic [22:0] extAddr;
  logic [31:0] extWdata, extRdata;
  logic        locEn, locWe;
  logic [12:0] locAddr;
  logic [31:0] locWdata, locRdata;

  always #2.5 clk = ~clk;

  rdma_engine i_rdma_engine (.*);

  logic [31:0] extMem [4096];
  logic [31:0] locMem [2048];
  logic [31:0] refExt [4096];
  logic [31:0] refLoc [2048];
  int          hsCount = 0;
  int          readyPct = 100;
  int          nChecks = 0;
  int          nErrors = 0;
  bit          finished = 1'b0;

  // Memory models, filled during reset
  assign extRdata = extMem[extAddr[13:2]];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4096; i++) extMem[i] <= (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
      for (int i = 0; i < 2048; i++) locMem[i] <= (32'(i) * 32'h7FEB352D) ^ 32'h0000C3C3;
    end else begin
      if (extValid && extReady && extWrite) extMem[extAddr[13:2]] <= extWdata;
      if (locEn && locWe) locMem[locAddr[12:2]] <= locWdata;
      if (locEn && !locWe) locRdata <= locMem[locAddr[12:2]];
      if (extValid && extReady) hsCount <= hsCount + 1;
    end
  end

  always @(negedge clk) extReady <= ($urandom % 100) < readyPct;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  // Reference transfer computed from the requirements
  logic [12:0] expLoc;
  logic [22:0] expExt;
  int          expWords;

  task automatic refRun(input logic [12:0] l0, input logic [22:0] e0,
                        input logic [31:0] d, input bit toLoc);
    logic [12:0] loc, len, lA;
    logic [22:0] ext, eA;
    int j;
    loc = l0 & ~13'd3;
    ext = e0 & ~23'd7;
    len = (13'(d[11:0]) + 13'd8) & ~13'd7;
    if (int'(loc[11:0]) + int'(len) > 4096) len = 13'(4096 - int'(loc[11:0]));
    expWords = 0;
    for (int r = 0; r <= int'(d[19:12]); r++) begin
      j = 0;
      do begin
        eA = (ext + 23'(j)) & 23'h7FFFFC;
        lA = (loc + 13'(j)) & 13'h1FFC;
        if (toLoc) refLoc[lA[12:2]] = refExt[eA[13:2]];
        else       refExt[eA[13:2]] = refLoc[lA[12:2]];
        expWords++;
        j += 4;
      end while (j < int'(len));
      if (toLoc) begin
        ext = ext + 23'(len);
        loc = loc + len + 13'(d[31:20]);
      end else begin
        loc = loc + len;
        ext = ext + 23'(len) + 23'(d[31:20]);
      end
    end
    expLoc = loc;
    expExt = ext;
  endtask

  int hsBase;
  logic [31:0] curDesc;
  bit curToLoc;

  task automatic startXfer(input logic [12:0] l, input logic [22:0] e,
                           input logic [31:0] d, input bit toLoc);
    wr(2'd0, 32'(l));
    wr(2'd1, 32'(e));
    for (int i = 0; i < 4096; i++) refExt[i] = extMem[i];
    for (int i = 0; i < 2048; i++) refLoc[i] = locMem[i];
    refRun(l, e, d, toLoc);
    curDesc = d;
    curToLoc = toLoc;
    hsBase = hsCount;
    wr(toLoc ? 2'd2 : 2'd3, d);
    check("R10 busy after start", 32'(busy), 32'd1);
  endtask

  task automatic finishXfer(input string hsTag);
    int t;
    int bad;
    logic [31:0] v;
    t = 0;
    while (!done && t < 50000) begin
      @(negedge clk);
      t++;
    end
    check("R10 done seen", 32'(done), 32'd1);
    check("R10 busy low at done", 32'(busy), 32'd0);
    @(negedge clk);
    check("R10 done one cycle", 32'(done), 32'd0);
    check({hsTag, " handshake count"}, 32'(hsCount - hsBase), 32'(expWords));
    bad = 0;
    for (int i = 0; i < 4096; i++) if (extMem[i] !== refExt[i]) bad++;
    for (int i = 0; i < 2048; i++) if (locMem[i] !== refLoc[i]) bad++;
    check("R5 memory contents", 32'(bad), 32'd0);
    rd(2'd0, v);
    check(curToLoc ? "R6 local addr" : "R7 local addr", v, 32'(expLoc));
    rd(2'd1, v);
    check(curToLoc ? "R6 ext addr" : "R7 ext addr", v, 32'(expExt));
    rd(curToLoc ? 2'd2 : 2'd3, v);
    check("R1 descriptor readback", v, curDesc);
  endtask

  function automatic logic [31:0] mkDesc(input int len, input int cnt, input int skip);
    return {12'(skip), 8'(cnt), 12'(len)};
  endfunction

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    check("R10 reset busy", 32'(busy), 32'd0);
    check("R10 reset done", 32'(done), 32'd0);
    check("R10 reset extValid", 32'(extValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: smallest length field gives two words
    readyPct = 100;
    startXfer(13'h010, 23'h000100, mkDesc(0, 0, 0), 1'b1);
    finishXfer("R2");
    // R3: misaligned addresses are aligned at start
    startXfer(13'h0107, 23'h00020F, mkDesc(5, 1, 16), 1'b0);
    finishXfer("R3");
    // R4: row clamped at the 4 KB bank edge
    startXfer(13'h0FF0, 23'h000400, mkDesc(63, 1, 32), 1'b1);
    finishXfer("R4");
    startXfer(13'h1FE8, 23'h000800, mkDesc(31, 0, 0), 1'b0);
    finishXfer("R4");
    // R5: both addresses wrap
    startXfer(13'h1FF8, 23'h7FFFF0, mkDesc(7, 2, 5), 1'b0);
    finishXfer("R5");
    startXfer(13'h0FF8, 23'h7FFFF8, mkDesc(7, 2, 3), 1'b1);
    finishXfer("R5");
    // R8: multi-row with count field
    startXfer(13'h0200, 23'h001000, mkDesc(15, 7, 8), 1'b1);
    finishXfer("R8");

    // R11: writes during busy are ignored
    readyPct = 30;
    startXfer(13'h0300, 23'h002000, mkDesc(63, 3, 4), 1'b0);
    wr(2'd0, 32'h0000_0ABC);
    wr(2'd1, 32'h0012_3450);
    wr(2'd2, mkDesc(3, 0, 0));
    finishXfer("R11");
    begin
      int hs0;
      hs0 = hsCount;
      repeat (10) @(negedge clk);
      check("R11 no second transfer", 32'(busy) + 32'(hsCount - hs0), 32'd0);
    end

    // R9: random stalls and random shapes
    for (int n = 0; n < 24; n++) begin
      readyPct = 20 + int'($urandom % 81);
      startXfer(13'($urandom), 23'($urandom),
                mkDesc(int'($urandom % 64), int'($urandom % 4), int'($urandom % 4096)),
                1'($urandom));
      finishXfer("R9");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule